// File: doc/BRIEF.md
# Memory-Mapped BCD Calendar Clock

This block is a byte-wide timekeeper that shares a 17-bit address space with general-purpose RAM. The clock occupies the eight highest locations and every lower address goes to a small byte RAM. A host accesses both through one synchronous port with active-low chip enable, write enable and output enable. A one-cycle tick pulse, once per second, advances a packed-BCD calendar: seconds, minutes, hours in 24-hour form, day of week, date, month and two-digit year.

The host sets the time by raising a hold bit in the control byte. This stops the tick from reaching the counters and opens the time bytes to writes. A second control bit freezes the copy of the time that the host reads, so a multi-byte read stays coherent while counting continues. A stop bit in the seconds byte halts timekeeping. A test flag in the day byte makes an output pin toggle on every tick.

Top module: `bcd_rtc_mem`

## Requirements
- R1: Addresses 1FFF8 to 1FFFF select the clock: offset 0 is control, then seconds, minutes, hours, day of week, date, month and year at offsets 1 to 7. Every other address reaches a RAM of 2^RAM_AW bytes indexed by the low RAM_AW address bits, so addresses that differ only above those bits alias. A clock write never alters RAM.
- R2: A read takes place at a clock edge with ce_n=0, we_n=1 and oe_n=0, and its byte appears on rdata one cycle later. After any other edge, rdata is 00.
- R3: Each tick adds one to seconds. Seconds and minutes wrap from 59 to 00, hours from 23 to 00, and each wrap carries into the next field.
- R4: A carry out of hours advances both the day of week and the date. The day of week wraps from 07 to 01. The month wraps from 12 to 01 and carries into the year, which wraps from 99 to 00.
- R5: The date wraps to 01 after day 30 in months 04, 06, 09 and 11, and after day 31 in the other months except February. February has 29 days when the binary value of the year is divisible by four and 28 days otherwise.
- R6: While bit 7 of the seconds byte (the stop bit) is 1, ticks leave every time field unchanged.
- R7: Control bit 7 is the write-hold bit. While it is 1, ticks are ignored and writes to offsets 1 to 7 load the fields. While it is 0, writes to offsets 1 to 7 are ignored. Counting resumes from the loaded values when the bit is cleared.
- R8: Control bit 6 is the read-hold bit. While it is 1, reads of offsets 1 to 7 return the values captured when it was set, and ticks still advance the counters. While it is 0, reads return the live values.
- R9: Unused bits read as 0. Control bits 5:0 and day-of-week bits 7 and 5:3 always read 0. Written values are masked to 7 bits for seconds and minutes (bit 7 of the seconds byte is the stop bit), 6 bits for hours and date, 5 bits for month and 3 bits for day of week. Day-of-week bit 6 is the frequency-test flag.
- R10: While the frequency-test flag is 1, ftest_out toggles on every tick. It starts at 0 when the flag is set. It is 0 whenever the flag is 0.
- R11: After reset, control, the stop bit and the test flag are 0, and the time reads 00:00:00 on day 01, date 01, month 01, year 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Write data |
| ce_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| tick | input | 1 | One-cycle pulse per second |
| rdata | output | 8 | Registered read data |
| ftest_out | output | 1 | Frequency-test toggle output |

## Verification
The bench targets the month-end corners: February in a year divisible by four and in a year that is not, a 30-day month, and the year-end rollover from 99. A design with a wrong length table or a broken carry chain reads back the wrong date, month or year after a single tick. A tick sent while the write-hold bit is 1 and a write sent while it is 0 check that the hold gates both paths; a design that leaks either path changes the seconds unexpectedly. The bench also sets the stop bit, freezes the read copy, writes all ones into the control and day bytes, and checks that clock writes do not reach the aliased RAM bytes.

// File: rtl/rtc_pkg.sv
// Shared constants, types and BCD helpers for the memory-mapped clock.
// Assumes all field values are packed BCD in one byte each.
package rtc_pkg;
    localparam int NUM_FIELDS = 7;
    localparam int FLD_SEC    = 0;
    localparam int FLD_MIN    = 1;
    localparam int FLD_HOUR   = 2;
    localparam int FLD_WDAY   = 3;
    localparam int FLD_DATE   = 4;
    localparam int FLD_MON    = 5;
    localparam int FLD_YEAR   = 6;

    typedef logic [NUM_FIELDS-1:0][7:0] time_vec_t;

    // Bits a field keeps on a write
    function automatic logic [7:0] field_mask(input int idx);
        case (idx)
            FLD_SEC, FLD_MIN:   return 8'h7F;
            FLD_HOUR, FLD_DATE: return 8'h3F;
            FLD_WDAY:           return 8'h07;
            FLD_MON:            return 8'h1F;
            default:            return 8'hFF;
        endcase
    endfunction

    // Lowest legal value of a field
    function automatic logic [7:0] field_min(input int idx);
        case (idx)
            FLD_WDAY, FLD_DATE, FLD_MON: return 8'h01;
            default:                     return 8'h00;
        endcase
    endfunction

    // Highest legal value of a field (date uses a dynamic limit instead)
    function automatic logic [7:0] field_max(input int idx);
        case (idx)
            FLD_SEC, FLD_MIN: return 8'h59;
            FLD_HOUR:         return 8'h23;
            FLD_WDAY:         return 8'h07;
            FLD_DATE:         return 8'h31;
            FLD_MON:          return 8'h12;
            default:          return 8'h99;
        endcase
    endfunction

    // Add one to a two-digit BCD value
    function automatic logic [7:0] bcd_inc(input logic [7:0] v);
        if (v[3:0] == 4'h9) return {v[7:4] + 4'h1, 4'h0};
        return v + 8'h01;
    endfunction

    // Last date of a month, BCD in and out
    function automatic logic [7:0] month_len(input logic [7:0] mon, input logic [7:0] yr);
        logic [7:0] ybin;
        ybin = ({4'h0, yr[7:4]} * 8'd10) + {4'h0, yr[3:0]};
        case (mon)
            8'h02:                      return (ybin[1:0] == 2'b00) ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: return 8'h30;
            default:                    return 8'h31;
        endcase
    endfunction
endpackage

// File: rtl/rtc_bcd_field.sv
// One BCD calendar field: loads on a host write, otherwise steps on inc.
// Assumes ld and inc are never both active; wraps to lo at or above hi.
module rtc_bcd_field
    import rtc_pkg::*;
#(
    parameter logic [7:0] MASK = 8'hFF,
    parameter logic [7:0] RST  = 8'h00
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc,
    input  logic       ld,
    input  logic [7:0] ld_val,
    input  logic [7:0] lo,
    input  logic [7:0] hi,
    output logic [7:0] val,
    output logic       wrap
);
    assign wrap = inc && (val >= hi);

    // Field register: reset, host load or BCD step
    always_ff @(posedge clk) begin
        if (!rst_n)   val <= RST;
        else if (ld)  val <= ld_val & MASK;
        else if (inc) val <= wrap ? lo : bcd_inc(val);
    end
endmodule

// File: rtl/rtc_time_core.sv
// Calendar counter chain with stop bit and test flag.
// Assumes tick is one cycle wide; host loads only while hold_wr is set.
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       hold_wr,
    input  logic       wr_en,
    input  logic [2:0] wr_sel,
    input  logic [7:0] wr_data,
    output time_vec_t  live,
    output logic       stop_bit,
    output logic       ft_bit
);
    logic [NUM_FIELDS-1:0]      inc;
    logic [NUM_FIELDS-1:0]      wrap;
    logic [NUM_FIELDS-1:0]      ld;
    logic [NUM_FIELDS-1:0][7:0] hi_w;
    logic [7:0]                 date_hi;
    logic                       load_ok;

    assign load_ok = wr_en && hold_wr;
    assign date_hi = month_len(live[FLD_MON], live[FLD_YEAR]);

    // Carry chain: sec -> min -> hour -> (weekday, date) -> month -> year
    assign inc[FLD_SEC]  = tick && !hold_wr && !stop_bit;
    assign inc[FLD_MIN]  = wrap[FLD_SEC];
    assign inc[FLD_HOUR] = wrap[FLD_MIN];
    assign inc[FLD_WDAY] = wrap[FLD_HOUR];
    assign inc[FLD_DATE] = wrap[FLD_HOUR];
    assign inc[FLD_MON]  = wrap[FLD_DATE];
    assign inc[FLD_YEAR] = wrap[FLD_MON];

    for (genvar i = 0; i < NUM_FIELDS; i++) begin : g_fld
        assign ld[i] = load_ok && (wr_sel == 3'(i));
        if (i == FLD_DATE) begin : g_dyn
            assign hi_w[i] = date_hi;
        end else begin : g_fix
            assign hi_w[i] = field_max(i);
        end
        rtc_bcd_field #(
            .MASK (field_mask(i)),
            .RST  (field_min(i))
        ) u_fld (
            .clk    (clk),
            .rst_n  (rst_n),
            .inc    (inc[i]),
            .ld     (ld[i]),
            .ld_val (wr_data),
            .lo     (field_min(i)),
            .hi     (hi_w[i]),
            .val    (live[i]),
            .wrap   (wrap[i])
        );
    end

    // Flag bits that share bytes with the seconds and weekday fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stop_bit <= 1'b0;
            ft_bit   <= 1'b0;
        end else begin
            if (ld[FLD_SEC])  stop_bit <= wr_data[7];
            if (ld[FLD_WDAY]) ft_bit   <= wr_data[6];
        end
    end
endmodule

// File: rtl/rtc_read_view.sv
// Readable copy of the time bytes: live, or frozen while hold is set.
// Assumes the copy is captured on every edge where hold is still clear.
module rtc_read_view
    import rtc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      hold,
    input  time_vec_t live_bytes,
    output time_vec_t view
);
    time_vec_t snap;

    // Track live bytes until the read hold is raised
    always_ff @(posedge clk) begin
        if (!rst_n)     snap <= '0;
        else if (!hold) snap <= live_bytes;
    end

    assign view = hold ? snap : live_bytes;
endmodule

// File: rtl/rtc_byte_ram.sv
// Plain byte RAM serving the non-clock addresses.
// Assumes a synchronous write and a combinational read; contents are not reset.
module rtc_byte_ram #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    q
);
    localparam int DEPTH = 1 << AW;
    logic [7:0] mem [DEPTH];

    // Store a byte on a write cycle
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign q = mem[addr];
endmodule

// File: rtl/bcd_rtc_mem.sv
// Top: decodes the host port, holds the control byte, muxes read data
// and drives the frequency-test output. Assumes a synchronous host port.
module bcd_rtc_mem
    import rtc_pkg::*;
#(
    parameter int ADDR_W = 17,
    parameter int RAM_AW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic              tick,
    output logic [7:0]        rdata,
    output logic              ftest_out
);
    localparam int OFF_W = 3;

    logic             is_clk;
    logic [OFF_W-1:0] off;
    logic             wr_cyc, rd_cyc;
    logic             time_wr, ctrl_wr;
    logic             wbit_q, rbit_q;
    logic             stop_bit, ft_bit;
    logic             ftgl_q;
    time_vec_t        live, live_bytes, view;
    logic [7:0]       ram_q, rd_mux;

    assign is_clk  = &addr[ADDR_W-1:OFF_W];
    assign off     = addr[OFF_W-1:0];
    assign wr_cyc  = !ce_n && !we_n;
    assign rd_cyc  = !ce_n && we_n && !oe_n;
    assign ctrl_wr = wr_cyc && is_clk && (off == '0);
    assign time_wr = wr_cyc && is_clk && (off != '0);

    // Control byte: write-hold and read-hold bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wbit_q <= 1'b0;
            rbit_q <= 1'b0;
        end else if (ctrl_wr) begin
            wbit_q <= wdata[7];
            rbit_q <= wdata[6];
        end
    end

    rtc_time_core u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .hold_wr  (wbit_q),
        .wr_en    (time_wr),
        .wr_sel   (off - 3'd1),
        .wr_data  (wdata),
        .live     (live),
        .stop_bit (stop_bit),
        .ft_bit   (ft_bit)
    );

    // Assemble the host-visible bytes including flag bits
    always_comb begin
        live_bytes           = live;
        live_bytes[FLD_SEC]  = {stop_bit, live[FLD_SEC][6:0]};
        live_bytes[FLD_WDAY] = {1'b0, ft_bit, 3'b000, live[FLD_WDAY][2:0]};
    end

    rtc_read_view u_view (
        .clk        (clk),
        .rst_n      (rst_n),
        .hold       (rbit_q),
        .live_bytes (live_bytes),
        .view       (view)
    );

    rtc_byte_ram #(.AW(RAM_AW)) u_ram (
        .clk   (clk),
        .we    (wr_cyc && !is_clk),
        .addr  (addr[RAM_AW-1:0]),
        .wdata (wdata),
        .q     (ram_q)
    );

    // Select the byte addressed by the host
    always_comb begin
        if (!is_clk) rd_mux = ram_q;
        else begin
            case (off)
                3'd0:    rd_mux = {wbit_q, rbit_q, 6'b0};
                3'd1:    rd_mux = view[FLD_SEC];
                3'd2:    rd_mux = view[FLD_MIN];
                3'd3:    rd_mux = view[FLD_HOUR];
                3'd4:    rd_mux = view[FLD_WDAY];
                3'd5:    rd_mux = view[FLD_DATE];
                3'd6:    rd_mux = view[FLD_MON];
                default: rd_mux = view[FLD_YEAR];
            endcase
        end
    end

    // Registered read data, zero outside read cycles
    always_ff @(posedge clk) begin
        if (!rst_n)      rdata <= 8'h00;
        else if (rd_cyc) rdata <= rd_mux;
        else             rdata <= 8'h00;
    end

    // Frequency-test toggle, held low while the flag is clear
    always_ff @(posedge clk) begin
        if (!rst_n || !ft_bit) ftgl_q <= 1'b0;
        else if (tick)         ftgl_q <= ~ftgl_q;
    end

    assign ftest_out = ftgl_q & ft_bit;
endmodule

// File: rtl/rtc_chk.sv
// Temporal checks on the clock block, bound to the top module.
module rtc_chk
    import rtc_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        tick,
    input logic [16:0] addr,
    input logic        ce_n,
    input logic        we_n,
    input logic        oe_n,
    input logic [7:0]  rdata,
    input logic        ftest_out,
    input logic        wbit_q,
    input logic        rbit_q,
    input logic        stop_bit,
    input logic        ft_bit,
    input logic        time_wr,
    input logic        ctrl_wr,
    input time_vec_t   live,
    input time_vec_t   view
);
    logic rd_now, rd_ctrl;
    assign rd_now  = !ce_n && we_n && !oe_n;
    assign rd_ctrl = rd_now && (addr == 17'h1FFF8);

    // R2
    rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_now |=> (rdata == 8'h00));

    // R3
    tick_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wbit_q && !stop_bit && !time_wr) |=> !$stable(live[FLD_SEC]));

    // R6
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_bit && !time_wr) |=> $stable(live));

    // R7
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wbit_q && !time_wr) |=> $stable(live));

    // R8
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rbit_q && !ctrl_wr) |=> $stable(view));

    // R9
    ctrl_unused_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |=> (rdata[5:0] == 6'b0));

    // R10
    ftest_tgl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ft_bit && tick) |=> (!ft_bit || (ftest_out != $past(ftest_out))));
endmodule

bind bcd_rtc_mem rtc_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .addr      (addr),
    .ce_n      (ce_n),
    .we_n      (we_n),
    .oe_n      (oe_n),
    .rdata     (rdata),
    .ftest_out (ftest_out),
    .wbit_q    (wbit_q),
    .rbit_q    (rbit_q),
    .stop_bit  (stop_bit),
    .ft_bit    (ft_bit),
    .time_wr   (time_wr),
    .ctrl_wr   (ctrl_wr),
    .live      (live),
    .view      (view)
);

// File: tb/sim_bcd_rtc_mem.sv
`timescale 1ns/1ps
module sim_bcd_rtc_mem;
    localparam logic [16:0] A_CTRL = 17'h1FFF8, A_SEC = 17'h1FFF9, A_MIN = 17'h1FFFA,
                            A_HOUR = 17'h1FFFB, A_WDAY = 17'h1FFFC, A_DATE = 17'h1FFFD,
                            A_MON = 17'h1FFFE, A_YEAR = 17'h1FFFF;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic [16:0] addr = '0;
    logic [7:0]  wdata = '0;
    logic        ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, tick = 1'b0;
    logic [7:0]  rdata;
    logic        ftest_out;

    always #2 clk = ~clk;

    bcd_rtc_mem u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .ce_n(ce_n),
                    .we_n(we_n), .oe_n(oe_n), .tick(tick), .rdata(rdata), .ftest_out(ftest_out));

    typedef struct { logic [7:0] exp; string tag; } item_t;
    item_t sbq[$];
    int    n_cmp = 0, n_bad = 0;
    logic  exp_flag = 1'b0, pend = 1'b0;

    // Mark cycles whose result is due on rdata one cycle later
    always @(posedge clk) pend <= exp_flag;

    // Monitor: pop and compare scoreboard items
    always @(negedge clk) begin
        if (pend) begin
            item_t it;
            if (sbq.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL scoreboard empty: got %02h expected none", rdata);
            end else begin
                it = sbq.pop_front();
                n_cmp++;
                if (rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: got %02h expected %02h", it.tag, rdata, it.exp);
                end
            end
        end
    end

    task automatic rd(input logic [16:0] a, input logic [7:0] e, input string tag, input bit oe = 1'b1);
        item_t it;
        @(negedge clk);
        addr = a; ce_n = 1'b0; we_n = 1'b1; oe_n = !oe; exp_flag = 1'b1;
        it.exp = e; it.tag = tag;
        sbq.push_back(it);
        @(negedge clk);
        ce_n = 1'b1; oe_n = 1'b1; exp_flag = 1'b0;
    endtask

    task automatic wr(input logic [16:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; ce_n = 1'b0; we_n = 1'b0;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic chk_ft(input logic e, input string tag);
        @(negedge clk);
        n_cmp++;
        if (ftest_out !== e) begin
            n_bad++;
            $display("FAIL %s: got %0b expected %0b", tag, ftest_out, e);
        end
    endtask

    task automatic set_time(input logic [7:0] s, mi, h, wd, dt, mo, y);
        wr(A_CTRL, 8'h80);
        wr(A_SEC, s); wr(A_MIN, mi); wr(A_HOUR, h); wr(A_WDAY, wd);
        wr(A_DATE, dt); wr(A_MON, mo); wr(A_YEAR, y);
        wr(A_CTRL, 8'h00);
    endtask

    task automatic finish_run();
        repeat (3) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        #(200000 * 4);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        rd(A_CTRL, 8'h00, "R11 ctrl");   rd(A_SEC, 8'h00, "R11 sec");
        rd(A_MIN, 8'h00, "R11 min");     rd(A_HOUR, 8'h00, "R11 hour");
        rd(A_WDAY, 8'h01, "R11 wday");   rd(A_DATE, 8'h01, "R11 date");
        rd(A_MON, 8'h01, "R11 month");   rd(A_YEAR, 8'h00, "R11 year");
        chk_ft(1'b0, "R11 ftest");

        // R1 RAM aliasing and isolation from clock writes
        wr(17'h00010, 8'hA5);
        rd(17'h1FF10, 8'hA5, "R1 alias");
        wr(17'h1FFF7, 8'h3C);
        rd(17'h000F7, 8'h3C, "R1 below clock");
        wr(17'h000F8, 8'h11);
        wr(A_CTRL, 8'h00);
        rd(17'h000F8, 8'h11, "R1 clock write kept off RAM");
        // R2 output enable inactive gives zero
        rd(17'h00010, 8'h00, "R2 oe inactive", 1'b0);

        // R7 writes ignored without hold
        wr(A_SEC, 8'h30);
        rd(A_SEC, 8'h00, "R7 write without hold");

        // R7 tick ignored while hold set
        wr(A_CTRL, 8'h80);
        wr(A_SEC, 8'h58);
        pulse(1);
        rd(A_SEC, 8'h58, "R7 tick during hold");
        wr(A_CTRL, 8'h00);

        // R3 R4 R5 end of February, non-leap year
        set_time(8'h58, 8'h59, 8'h23, 8'h07, 8'h28, 8'h02, 8'h23);
        pulse(1);
        rd(A_SEC, 8'h59, "R3 sec step");
        pulse(1);
        rd(A_SEC, 8'h00, "R3 sec wrap");   rd(A_MIN, 8'h00, "R3 min wrap");
        rd(A_HOUR, 8'h00, "R3 hour wrap"); rd(A_WDAY, 8'h01, "R4 wday wrap");
        rd(A_DATE, 8'h01, "R5 feb 28 days"); rd(A_MON, 8'h03, "R5 month after feb");
        rd(A_YEAR, 8'h23, "R4 year held");

        // R5 leap February
        set_time(8'h59, 8'h59, 8'h23, 8'h03, 8'h28, 8'h02, 8'h24);
        pulse(1);
        rd(A_DATE, 8'h29, "R5 leap feb 29"); rd(A_MON, 8'h02, "R5 leap month held");
        rd(A_WDAY, 8'h04, "R4 wday step");
        set_time(8'h59, 8'h59, 8'h23, 8'h04, 8'h29, 8'h02, 8'h24);
        pulse(1);
        rd(A_DATE, 8'h01, "R5 leap feb end"); rd(A_MON, 8'h03, "R5 leap next month");

        // R5 thirty-day month
        set_time(8'h59, 8'h59, 8'h23, 8'h02, 8'h30, 8'h04, 8'h25);
        pulse(1);
        rd(A_DATE, 8'h01, "R5 april end"); rd(A_MON, 8'h05, "R5 may");

        // R4 year rollover
        set_time(8'h59, 8'h59, 8'h23, 8'h05, 8'h31, 8'h12, 8'h99);
        pulse(1);
        rd(A_YEAR, 8'h00, "R4 year wrap"); rd(A_MON, 8'h01, "R4 month wrap");
        rd(A_DATE, 8'h01, "R4 date wrap");

        // R6 stop bit
        wr(A_CTRL, 8'h80); wr(A_SEC, 8'h90); wr(A_CTRL, 8'h00);
        pulse(3);
        rd(A_SEC, 8'h90, "R6 stopped");
        wr(A_CTRL, 8'h80); wr(A_SEC, 8'h10); wr(A_CTRL, 8'h00);
        pulse(1);
        rd(A_SEC, 8'h11, "R6 restarted");

        // R9 masking of unused bits
        wr(A_CTRL, 8'h80); wr(A_WDAY, 8'hFF);
        rd(A_WDAY, 8'h47, "R9 wday mask");
        wr(A_CTRL, 8'hFF);
        rd(A_CTRL, 8'hC0, "R9 ctrl mask");
        wr(A_CTRL, 8'h00);

        // R10 frequency-test toggle (flag now set)
        chk_ft(1'b0, "R10 start low");
        pulse(1); chk_ft(1'b1, "R10 first toggle");
        pulse(1); chk_ft(1'b0, "R10 second toggle");
        pulse(1); chk_ft(1'b1, "R10 third toggle");
        wr(A_CTRL, 8'h80); wr(A_WDAY, 8'h01); wr(A_CTRL, 8'h00);
        chk_ft(1'b0, "R10 flag cleared");
        pulse(1); chk_ft(1'b0, "R10 idle with flag clear");

        // R8 read hold
        wr(A_CTRL, 8'h80); wr(A_SEC, 8'h00); wr(A_CTRL, 8'h40);
        pulse(2);
        rd(A_SEC, 8'h00, "R8 frozen copy");
        wr(A_CTRL, 8'h00);
        rd(A_SEC, 8'h02, "R8 counting continued");

        finish_run();
    end
endmodule